// File: doc/BRIEF.md
# Multi-Channel Countdown Timer Unit

This peripheral holds three down-counting channels and one up-counting free-running counter. All of them sit behind a simple synchronous register bus. Two of the countdown channels are narrow (16 bits by default) and one is wide (32 bits by default). Each countdown channel has four registers: a reload register, a live count register, a control word and an acknowledge register. On underflow a channel either reloads itself (periodic mode) or wraps to all ones (free mode). In both cases it raises a sticky interrupt, which stays set until software writes the acknowledge register.

Two tick-enable inputs drive the counting. A slow time base (about 508 kHz in the target system) and a fast time base (983.04 kHz) are supplied as single-cycle enables in the bus clock domain. Each countdown channel picks one of the two with a bit in its control word.

The free-running counter is 40 bits wide by default and counts fast ticks only. It is switched on and off by one bit in its high-word register and never interrupts. Reading its low word also captures its upper bits, so a later high-word read returns a value that matches the earlier low-word read.

Top module: `timer_unit`

## Requirements
- R1: After reset every count, reload value and control word reads as zero, every interrupt output is low, and the free-running counter reads zero with its enable clear.
- R2: Channel register groups start at 0x00, 0x20 and 0x80. Within a group the reload register is at +0x0, the live count at +0x4, the control word at +0x8 and the acknowledge register at +0xC. Writing the reload register also loads the count. Both values are truncated to the channel width and read back zero-extended.
- R3: In the control word, bit 7 enables counting, bit 6 selects periodic mode and bit 3 selects the slow tick. A read of the control word returns only these three bits; every other bit reads as zero.
- R4: An enabled channel decrements by one on each pulse of its selected tick: the slow tick when bit 3 is 1, the fast tick when bit 3 is 0. It holds its count when disabled or when only the unselected tick pulses.
- R5: In periodic mode an underflow reloads the count from the reload register, so a reload value N gives exactly N+1 ticks from enabling to the first interrupt.
- R6: In free mode an underflow wraps the count to all ones of the channel width, and the interrupt is still raised.
- R7: An underflow sets the channel's interrupt output, which stays high until any value is written to that channel's acknowledge register. If an underflow and an acknowledge happen in the same cycle, the underflow wins.
- R8: Writing 0x64 with bit 8 set enables the free-running counter, which then increments on every fast tick. Writing it with bit 8 clear stops the counter and holds it at zero.
- R9: A read of 0x60 returns the low bits of the free-running counter and captures its upper bits. A read of 0x64 returns the enable in bit 8 and the captured upper bits in bits 7:0. A high-word read is not changed by counting that happens after the last low-word read.
- R10: The free-running counter has no interrupt; running it leaves every interrupt output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counting clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_re | input | 1 | Read strobe (needed for the low-word capture) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, combinational |
| slow_tick | input | 1 | Slow time-base enable pulse |
| fast_tick | input | 1 | Fast time-base enable pulse |
| irq | output | 3 | Per-channel interrupt, bit i for countdown channel i |

## Verification
The bench builds the unit with 4-bit narrow channels, an 8-bit wide channel and a 12-bit free-running counter whose low word is 8 bits. These small widths let it sweep every reload value of every channel in periodic mode and measure each period in ticks. They also let the free-running counter carry into its upper bits within a few hundred fast ticks. That carry is what makes the low/high capture observable: the bench reads the high word both before and after a carry that happens between reads.

// File: rtl/timer_pkg.sv
package timer_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int NUM_CH = 3;

    // register offsets inside one channel group
    localparam logic [ADDR_W-1:0] OFF_RELOAD = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_COUNT  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_ACK    = 8'h0C;

    // free-running counter words
    localparam logic [ADDR_W-1:0] FREE_LO_ADDR = 8'h60;
    localparam logic [ADDR_W-1:0] FREE_HI_ADDR = 8'h64;
    localparam int FREE_EN_BIT = 8;

    // control word bit positions
    localparam int CTL_RUN_BIT  = 7;
    localparam int CTL_PER_BIT  = 6;
    localparam int CTL_SLOW_BIT = 3;

    typedef struct packed {
        logic run;
        logic periodic;
        logic slow_sel;
    } chan_ctrl_t;

    function automatic logic [ADDR_W-1:0] group_base(input int ch);
        case (ch)
            0:       return 8'h00;
            1:       return 8'h20;
            default: return 8'h80;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] reg_addr(input int ch, input logic [ADDR_W-1:0] off);
        return group_base(ch) | off;
    endfunction

    function automatic chan_ctrl_t ctrl_unpack(input logic [DATA_W-1:0] w);
        chan_ctrl_t c;
        c.run      = w[CTL_RUN_BIT];
        c.periodic = w[CTL_PER_BIT];
        c.slow_sel = w[CTL_SLOW_BIT];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_pack(input chan_ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CTL_RUN_BIT]  = c.run;
        w[CTL_PER_BIT]  = c.periodic;
        w[CTL_SLOW_BIT] = c.slow_sel;
        return w;
    endfunction

endpackage

// File: rtl/tmr_down_chan.sv
module tmr_down_chan
    import timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_tick,
    input  logic              fast_tick,
    input  logic              wr_reload,
    input  logic              wr_ctrl,
    input  logic              wr_ack,
    input  logic [DATA_W-1:0] wdata,
    output logic [W-1:0]      count,
    output logic [W-1:0]      reload,
    output chan_ctrl_t        ctrl,
    output logic              irq,
    output logic              underflow
);

    logic step;

    assign step      = ctrl.run && (ctrl.slow_sel ? slow_tick : fast_tick);
    // a reload write takes priority over the tick in the same cycle
    assign underflow = step && (count == '0) && !wr_reload;

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            reload <= '0;
            ctrl   <= '0;
            irq    <= 1'b0;
        end else begin
            if (wr_ctrl)
                ctrl <= ctrl_unpack(wdata);

            if (wr_reload) begin
                reload <= wdata[W-1:0];
                count  <= wdata[W-1:0];
            end else if (step) begin
                if (count == '0)
                    count <= ctrl.periodic ? reload : '1;
                else
                    count <= count - 1'b1;
            end

            if (underflow)
                irq <= 1'b1;
            else if (wr_ack)
                irq <= 1'b0;
        end
    end

endmodule

// File: rtl/tmr_free_cnt.sv
module tmr_free_cnt
    import timer_pkg::*;
#(
    parameter int FREE_W = 40,
    parameter int LO_W   = 32,
    localparam int HI_W  = FREE_W - LO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fast_tick,
    input  logic              wr_cfg,
    input  logic              cfg_en,
    input  logic              rd_lo,
    output logic [FREE_W-1:0] value,
    output logic              enabled,
    output logic [HI_W-1:0]   hi_snap
);

    always_ff @(posedge clk) begin
        if (rst) begin
            value   <= '0;
            enabled <= 1'b0;
            hi_snap <= '0;
        end else begin
            if (wr_cfg)
                enabled <= cfg_en;

            if (!enabled)
                value <= '0;
            else if (fast_tick)
                value <= value + 1'b1;

            if (rd_lo)
                hi_snap <= value[FREE_W-1:LO_W];
        end
    end

endmodule

// File: rtl/timer_unit.sv
module timer_unit
    import timer_pkg::*;
#(
    parameter int NARROW_W  = 16,
    parameter int WIDE_W    = 32,
    parameter int FREE_W    = 40,
    parameter int FREE_LO_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              slow_tick,
    input  logic              fast_tick,
    output logic [NUM_CH-1:0] irq
);

    localparam int FREE_HI_W = FREE_W - FREE_LO_W;

    logic [DATA_W-1:0] ch_cnt32    [NUM_CH];
    logic [DATA_W-1:0] ch_reload32 [NUM_CH];
    logic [DATA_W-1:0] ch_ctrl32   [NUM_CH];
    logic [NUM_CH-1:0] ch_uf;
    logic [NUM_CH-1:0] ch_en;

    logic [FREE_W-1:0]    fr_cnt;
    logic                 fr_en;
    logic [FREE_HI_W-1:0] fr_hi_snap;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int CW = (i == NUM_CH - 1) ? WIDE_W : NARROW_W;

        logic [CW-1:0] cnt_w;
        logic [CW-1:0] rel_w;
        chan_ctrl_t    ctl_w;

        tmr_down_chan #(.W(CW)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .slow_tick (slow_tick),
            .fast_tick (fast_tick),
            .wr_reload (bus_we && bus_addr == reg_addr(i, OFF_RELOAD)),
            .wr_ctrl   (bus_we && bus_addr == reg_addr(i, OFF_CTRL)),
            .wr_ack    (bus_we && bus_addr == reg_addr(i, OFF_ACK)),
            .wdata     (bus_wdata),
            .count     (cnt_w),
            .reload    (rel_w),
            .ctrl      (ctl_w),
            .irq       (irq[i]),
            .underflow (ch_uf[i])
        );

        assign ch_cnt32[i]    = DATA_W'(cnt_w);
        assign ch_reload32[i] = DATA_W'(rel_w);
        assign ch_ctrl32[i]   = ctrl_pack(ctl_w);
        assign ch_en[i]       = ctl_w.run;
    end

    tmr_free_cnt #(.FREE_W(FREE_W), .LO_W(FREE_LO_W)) u_free (
        .clk       (clk),
        .rst       (rst),
        .fast_tick (fast_tick),
        .wr_cfg    (bus_we && bus_addr == FREE_HI_ADDR),
        .cfg_en    (bus_wdata[FREE_EN_BIT]),
        .rd_lo     (bus_re && bus_addr == FREE_LO_ADDR),
        .value     (fr_cnt),
        .enabled   (fr_en),
        .hi_snap   (fr_hi_snap)
    );

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == reg_addr(i, OFF_RELOAD)) bus_rdata = ch_reload32[i];
            if (bus_addr == reg_addr(i, OFF_COUNT))  bus_rdata = ch_cnt32[i];
            if (bus_addr == reg_addr(i, OFF_CTRL))   bus_rdata = ch_ctrl32[i];
        end
        if (bus_addr == FREE_LO_ADDR)
            bus_rdata = DATA_W'(fr_cnt[FREE_LO_W-1:0]);
        if (bus_addr == FREE_HI_ADDR) begin
            bus_rdata[FREE_EN_BIT] = fr_en;
            bus_rdata[7:0]         = 8'(fr_hi_snap);
        end
    end

endmodule

// File: rtl/timer_unit_chk.sv
module timer_unit_chk
    import timer_pkg::*;
#(
    parameter int FREE_W = 40
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              fast_tick,
    input logic [NUM_CH-1:0] irq,
    input logic [NUM_CH-1:0] ch_uf,
    input logic [NUM_CH-1:0] ch_en,
    input logic [DATA_W-1:0] ch_cnt32 [NUM_CH],
    input logic [FREE_W-1:0] fr_cnt,
    input logic              fr_en
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R7
        ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_we && bus_addr == reg_addr(i, OFF_ACK) && !ch_uf[i]) |=> !irq[i]);

        // R7
        uf_irq_chk: assert property (@(posedge clk) disable iff (rst)
            ch_uf[i] |=> irq[i]);

        // R4
        idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!ch_en[i] && !(bus_we && bus_addr == reg_addr(i, OFF_RELOAD)))
            |=> $stable(ch_cnt32[i]));
    end

    // R8
    free_step_chk: assert property (@(posedge clk) disable iff (rst)
        (fr_en && fast_tick && !(bus_we && bus_addr == FREE_HI_ADDR))
        |=> fr_cnt == FREE_W'($past(fr_cnt) + 1'b1));

    // R8
    free_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!fr_en && !(bus_we && bus_addr == FREE_HI_ADDR)) |=> fr_cnt == '0);

endmodule

bind timer_unit timer_unit_chk #(.FREE_W(FREE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .fast_tick (fast_tick),
    .irq       (irq),
    .ch_uf     (ch_uf),
    .ch_en     (ch_en),
    .ch_cnt32  (ch_cnt32),
    .fr_cnt    (fr_cnt),
    .fr_en     (fr_en)
);

// File: tb/sim_timer_unit.sv
`timescale 1ns/1ps
module sim_timer_unit;

    localparam int NW = 4;
    localparam int WW = 8;
    localparam int FW = 12;
    localparam int LW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        slow_tick = 1'b1;
    logic        fast_tick = 1'b0;
    logic [2:0]  irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    timer_unit #(.NARROW_W(NW), .WIDE_W(WW), .FREE_W(FW), .FREE_LO_W(LW)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .slow_tick(slow_tick),
        .fast_tick(fast_tick), .irq(irq)
    );

    function automatic logic [7:0] gb(input int ch);
        return (ch == 0) ? 8'h00 : (ch == 1) ? 8'h20 : 8'h80;
    endfunction

    function automatic int cw(input int ch);
        return (ch == 2) ? WW : NW;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic quiet(input int ch);
        wr(gb(ch) + 8'h08, 32'h0);
        wr(gb(ch) + 8'h0C, 32'h0);
    endtask

    // runs one underflow, returns ticks to irq and the count seen then
    task automatic run_to_irq(input int ch, input int n, input logic [31:0] ctl,
                              output int k, output logic [31:0] v);
        quiet(ch);
        wr(gb(ch) + 8'h00, n);
        wr(gb(ch) + 8'h08, ctl);
        k = 0;
        while (!irq[ch] && k < 2000) begin
            @(negedge clk);
            k++;
        end
        bus_addr = gb(ch) + 8'h04;
        #1 v = bus_rdata;
        quiet(ch);
    endtask

    task automatic finish_run;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        int k;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 irq", {29'b0, irq}, 32'h0);
        for (int ch = 0; ch < 3; ch++) begin
            rd(gb(ch) + 8'h00, v); check("R1 reload", v, 0);
            rd(gb(ch) + 8'h04, v); check("R1 count", v, 0);
            rd(gb(ch) + 8'h08, v); check("R1 ctrl", v, 0);
        end
        rd(8'h60, v); check("R1 free lo", v, 0);
        rd(8'h64, v); check("R1 free hi", v, 0);

        // R2 reload write loads count, truncated to width
        for (int ch = 0; ch < 3; ch++) begin
            wr(gb(ch) + 8'h00, 32'hFFFF_FFFF);
            rd(gb(ch) + 8'h00, v); check("R2 reload trunc", v, (32'd1 << cw(ch)) - 1);
            rd(gb(ch) + 8'h04, v); check("R2 count copy", v, (32'd1 << cw(ch)) - 1);
        end

        // R3 control readback
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h28, v); check("R3 ctrl bits", v, 32'hC8);
        quiet(1);

        // R4 disabled channel holds
        wr(8'h00, 7);
        wr(8'h08, 32'h48);
        repeat (6) @(negedge clk);
        rd(8'h04, v); check("R4 hold disabled", v, 7);

        // R4 fast tick selected, slow tick ignored
        wr(8'h00, 5);
        wr(8'h08, 32'h80);
        repeat (5) @(negedge clk);
        rd(8'h04, v); check("R4 unselected tick ignored", v, 5);
        fast_tick = 1'b1;
        repeat (3) @(negedge clk);
        fast_tick = 1'b0;
        bus_addr = 8'h04; #1 v = bus_rdata;
        check("R4 fast count", v, 2);
        quiet(0);

        // R5 period sweep over every reload value
        for (int ch = 0; ch < 3; ch++) begin
            for (int n = 0; n < (1 << cw(ch)); n++) begin
                run_to_irq(ch, n, 32'hC8, k, v);
                check("R5 period", k, n + 1);
                check("R5 reload value", v, n);
            end
        end

        // R6 free mode wraps to all ones
        for (int ch = 0; ch < 3; ch++) begin
            for (int n = 0; n < 3; n++) begin
                run_to_irq(ch, n, 32'h88, k, v);
                check("R6 ticks", k, n + 1);
                check("R6 wrap", v, (32'd1 << cw(ch)) - 1);
            end
        end

        // R7 irq sticky, cleared by any ack data
        run_to_irq(1, 2, 32'h88, k, v);
        wr(8'h20, 3);
        wr(8'h28, 32'hC8);
        repeat (6) @(negedge clk);
        wr(8'h28, 32'h0);
        repeat (4) @(negedge clk);
        check("R7 sticky", {31'b0, irq[1]}, 1);
        wr(8'h2C, 32'h1234_5678);
        check("R7 ack clears", {31'b0, irq[1]}, 0);

        // R8 / R9 / R10 free-running counter
        wr(8'h64, 32'h100);
        fast_tick = 1'b1;
        repeat (300) @(negedge clk);
        fast_tick = 1'b0;
        check("R10 no irq", {29'b0, irq}, 0);
        rd(8'h60, v); check("R9 lo", v, 300 % 256);
        rd(8'h64, v); check("R9 hi", v, 32'h101);
        fast_tick = 1'b1;
        repeat (250) @(negedge clk);
        fast_tick = 1'b0;
        rd(8'h64, v); check("R9 hi held", v, 32'h101);
        rd(8'h60, v); check("R8 count", v, 550 % 256);
        rd(8'h64, v); check("R9 hi updated", v, 32'h102);
        check("R10 no irq", {29'b0, irq}, 0);
        wr(8'h64, 32'h0);
        fast_tick = 1'b1;
        repeat (5) @(negedge clk);
        fast_tick = 1'b0;
        rd(8'h60, v); check("R8 off lo", v, 0);
        rd(8'h64, v); check("R8 off hi", v, 0);

        done = 1;
        finish_run();
    end

endmodule